// File: doc/BRIEF.md
# Dual-Edge Pulse and Period Capture with Coherent Readout

This block measures the time between two chosen edges of one input signal. A free-running counter sets the time base. The block can measure:

- the width of a high pulse,
- the width of a low pulse,
- a full period, taken between two rising edges or between two falling edges.

Each of the two edges stamps the counter into its own hidden buffer. The two visible registers are not written directly when an edge arrives. Software subtracts the first visible value from the second to get the width in counter ticks. Converting ticks into time, and raising interrupts, are left to the surrounding logic.

Coherency comes from how the visible registers are refreshed. The first visible register changes only when a measurement completes. The second visible register changes only when software strobes a read of the first. Software must read the first register, then the second. Read in that order, the pair always belongs to the same measurement, even if new edges arrive between the two reads. Read the other way round, the pair can be mixed. A done flag rises when a measurement completes and falls when the first register is read.

Top module: `edge_pair_capture`

## Requirements
- R1: While reset is asserted, and right after it is released, `firstVal`, `secondVal` and `captureDone` are all zero.
- R2: The counter is zero at reset and increases by one every clock. A first edge stores the counter value of the clock in which the edge is seen into a hidden buffer. `firstVal`, `secondVal` and `captureDone` do not change.
- R3: A second edge stores the counter into the second hidden buffer. At the same clock, `firstVal` takes the first buffer and `captureDone` is set. `secondVal` does not change.
- R4: A one-cycle `readFirst` strobe copies the second buffer into `secondVal` and clears `captureDone`. `secondVal - firstVal` is then the measured width in clocks.
- R5: `measMode` selects the edges. 00 is a high pulse (rise, then fall). 01 is a low pulse (fall, then rise). 10 is a period between rising edges. 11 is a period between falling edges. Edges of the other polarity are ignored.
- R6: In the period modes, the edge that completes a measurement does not also start the next one. A new measurement needs two further edges.
- R7: A third edge before the read lands only in a buffer. The read that follows still returns the earlier, complete pair.
- R8: A fourth edge before the read completes a newer measurement. `firstVal` takes the third edge's stamp, and the earlier pair is lost.
- R9: A read in the same clock as a second edge copies the second buffer as it was before that edge. `firstVal` takes the new first stamp, and `captureDone` stays set.
- R10: A change of `measMode` abandons a measurement that has seen only its first edge. Edges are ignored in the clock in which the mode changes.
- R11: The input level present when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Signal being measured, synchronous to clk |
| measMode | input | 2 | Measurement kind (encoding in R5) |
| readFirst | input | 1 | One-cycle strobe marking a read of firstVal |
| firstVal | output | CNT_W | Visible stamp of the first edge |
| secondVal | output | CNT_W | Visible stamp of the second edge |
| captureDone | output | 1 | A completed measurement is waiting to be read |

## Verification
A table of measurements covers all four edge selections with different widths, including a one-clock pulse. These cases separate correct polarity decoding from swapped polarities or an off-by-one stamp.

Directed sequences then test the coherency rules:
- a third edge arriving before the read, which separates buffered from direct capture;
- a fourth edge arriving before the read;
- a read that lands in the same clock as a completing edge;
- back-to-back periods, which catch reuse of the completing edge;
- a mode change in the middle of a measurement;
- a high input level at reset release, which catches a false first edge.

// File: rtl/edge_pair_pkg.sv
package edge_pair_pkg;

  // Edge selection; bit 0 picks the polarity of the first edge (0 rise, 1 fall),
  // bit 1 picks whether the second edge repeats it (period) or opposes it (pulse)
  typedef enum logic [1:0] {
    MEAS_HIGH     = 2'b00,
    MEAS_LOW      = 2'b01,
    MEAS_PER_RISE = 2'b10,
    MEAS_PER_FALL = 2'b11
  } measMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFirstBuf;   // stamp counter into first buffer
    logic loadSecondBuf;  // stamp counter into second buffer, publish first buffer
    logic copySecond;     // publish second buffer
  } capStrobe_t;

endpackage

// File: rtl/edge_pair_sel.sv
module edge_pair_sel
  import edge_pair_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sigIn,
  input  measMode_e mode,
  output logic      firstEdge,
  output logic      secondEdge
);

  logic sigPrev;
  logic primed;
  logic riseSeen;
  logic fallSeen;

  // primed blocks the first sample after reset, so the level at release is no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigPrev <= 1'b0;
      primed  <= 1'b0;
    end else begin
      sigPrev <= sigIn;
      primed  <= 1'b1;
    end
  end

  assign riseSeen = primed &  sigIn & ~sigPrev;
  assign fallSeen = primed & ~sigIn &  sigPrev;

  always_comb begin
    unique case (mode)
      MEAS_HIGH: begin
        firstEdge  = riseSeen;
        secondEdge = fallSeen;
      end
      MEAS_LOW: begin
        firstEdge  = fallSeen;
        secondEdge = riseSeen;
      end
      MEAS_PER_RISE: begin
        firstEdge  = riseSeen;
        secondEdge = riseSeen;
      end
      default: begin
        firstEdge  = fallSeen;
        secondEdge = fallSeen;
      end
    endcase
  end

  AST_EDGE_IS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (firstEdge || secondEdge) |-> (sigIn != $past(sigIn)));  // R11

  AST_HIGH_PULSE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MEAS_HIGH && secondEdge) |-> !sigIn);  // R5

  AST_LOW_PULSE_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MEAS_LOW && secondEdge) |-> sigIn);  // R5

endmodule

// File: rtl/edge_pair_ctrl.sv
module edge_pair_ctrl
  import edge_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  measMode_e  mode,
  input  logic       firstEdge,
  input  logic       secondEdge,
  input  logic       readFirst,
  output capStrobe_t strb,
  output logic       captureDone
);

  logic      armed;    // first edge taken, waiting for the second
  measMode_e modeQ;
  logic      modeChg;

  assign modeChg = (mode != modeQ);

  always_comb begin
    strb = '0;
    if (!modeChg) begin
      if (!armed && firstEdge)  strb.loadFirstBuf  = 1'b1;
      if (armed  && secondEdge) strb.loadSecondBuf = 1'b1;
    end
    strb.copySecond = readFirst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b0;
      modeQ       <= MEAS_HIGH;
      captureDone <= 1'b0;
    end else begin
      modeQ <= mode;
      if (modeChg)                 armed <= 1'b0;
      else if (strb.loadFirstBuf)  armed <= 1'b1;
      else if (strb.loadSecondBuf) armed <= 1'b0;
      // a completing edge outranks a read in the same clock
      if (strb.loadSecondBuf)  captureDone <= 1'b1;
      else if (readFirst)      captureDone <= 1'b0;
    end
  end

  AST_DONE_ON_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSecondBuf |=> captureDone);  // R3

  AST_DONE_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (readFirst && !strb.loadSecondBuf) |=> !captureDone);  // R4

  AST_NO_STAMP_ON_MODE_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (mode != modeQ) |-> !(strb.loadFirstBuf || strb.loadSecondBuf));  // R10

  AST_ABANDON_ON_MODE_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (armed && mode != modeQ) |=> !strb.loadSecondBuf);  // R10

  AST_NO_REUSE_OF_CLOSING_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSecondBuf |=> !strb.loadSecondBuf);  // R6

endmodule

// File: rtl/edge_pair_dp.sv
module edge_pair_dp
  import edge_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobe_t       strb,
  output logic [CNT_W-1:0] firstVal,
  output logic [CNT_W-1:0] secondVal
);

  localparam int NCH = 2;

  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0]            bufLoad;
  logic [NCH-1:0]            visLoad;
  logic [NCH-1:0][CNT_W-1:0] visAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  // channel 0: buffered on first edge, published on second edge
  // channel 1: buffered on second edge, published on read of channel 0
  assign bufLoad = {strb.loadSecondBuf, strb.loadFirstBuf};
  assign visLoad = {strb.copySecond,    strb.loadSecondBuf};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] bufReg;
    logic [CNT_W-1:0] visReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufReg <= '0;
        visReg <= '0;
      end else begin
        if (bufLoad[ch]) bufReg <= cnt;
        if (visLoad[ch]) visReg <= bufReg;
      end
    end
    assign visAll[ch] = visReg;
  end

  assign firstVal  = visAll[0];
  assign secondVal = visAll[1];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (cnt == $past(cnt) + 1'b1));  // R2

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSecondBuf |=> $stable(firstVal));  // R7

  AST_SECOND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.copySecond |=> $stable(secondVal));  // R4

endmodule

// File: rtl/edge_pair_capture.sv
module edge_pair_capture
  import edge_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [1:0]       measMode,
  input  logic             readFirst,
  output logic [CNT_W-1:0] firstVal,
  output logic [CNT_W-1:0] secondVal,
  output logic             captureDone
);

  measMode_e  modeSel;
  logic       firstEdge;
  logic       secondEdge;
  capStrobe_t strb;

  assign modeSel = measMode_e'(measMode);

  edge_pair_sel sel_i (
    .clk        (clk),
    .rstN       (rstN),
    .sigIn      (sigIn),
    .mode       (modeSel),
    .firstEdge  (firstEdge),
    .secondEdge (secondEdge)
  );

  edge_pair_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .mode        (modeSel),
    .firstEdge   (firstEdge),
    .secondEdge  (secondEdge),
    .readFirst   (readFirst),
    .strb        (strb),
    .captureDone (captureDone)
  );

  edge_pair_dp #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .firstVal  (firstVal),
    .secondVal (secondVal)
  );

endmodule

// File: tb/edge_pair_capture_tb_top.sv
`timescale 1ns/1ps
module edge_pair_capture_tb_top;

  localparam int CNT_W = 16;
  localparam int NV = 6;
  // measurement table: mode, full width in clocks, high/low phase for periods
  localparam int VEC_MODE [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int VEC_A    [NV] = '{5, 7, 9, 6, 1, 3};
  localparam int VEC_B    [NV] = '{0, 0, 4, 2, 0, 1};

  logic             clk = 1'b0;
  logic             rstN;
  logic             sigIn;
  logic [1:0]       measMode;
  logic             readFirst;
  logic [CNT_W-1:0] firstVal;
  logic [CNT_W-1:0] secondVal;
  logic             captureDone;

  int  cyc;
  int  nChk = 0;
  int  nBad = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  edge_pair_capture #(.CNT_W(CNT_W)) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .sigIn       (sigIn),
    .measMode    (measMode),
    .readFirst   (readFirst),
    .firstVal    (firstVal),
    .secondVal   (secondVal),
    .captureDone (captureDone)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a level; the stamp is the counter value seen at the next edge
  task automatic drv(input logic v, output int st);
    sigIn = v;
    st = cyc & 16'hFFFF;
    @(negedge clk);
  endtask

  task automatic doRead();
    readFirst = 1'b1;
    @(negedge clk);
    readFirst = 1'b0;
  endtask

  task automatic measure(input int m, input int a, input int b, input bit chkMid,
                         output int s1, output int s2);
    int  scratch;
    int  prevFirst;
    int  prevSecond;
    logic fp;
    fp = (m == 0 || m == 2);
    prevFirst  = firstVal;
    prevSecond = secondVal;
    drv(fp, s1);
    if (chkMid) begin
      check("R2 first edge leaves firstVal", firstVal, prevFirst);
      check("R2 first edge leaves secondVal", secondVal, prevSecond);
      check("R2 first edge leaves done", captureDone, 0);
    end
    if (m < 2) begin
      tick(a - 1);
      drv(!fp, s2);
    end else begin
      tick(b - 1);
      drv(!fp, scratch);
      tick(a - b - 1);
      drv(fp, s2);
    end
  endtask

  initial begin
    int s1, s2, s3, s4, x;
    rstN = 1'b0; sigIn = 1'b1; measMode = 2'b00; readFirst = 1'b0;
    tick(3);
    check("R1 firstVal in reset", firstVal, 0);
    check("R1 done in reset", captureDone, 0);
    rstN = 1'b1;
    tick(2);
    check("R1 firstVal after reset", firstVal, 0);
    check("R1 secondVal after reset", secondVal, 0);
    check("R1 done after reset", captureDone, 0);

    // R11: high level at release is no rise, so this fall must not complete anything
    drv(1'b0, x);
    tick(2);
    check("R11 reset level not an edge", captureDone, 0);

    // table of measurements, R2..R5
    for (int i = 0; i < NV; i++) begin
      int prevSecond;
      measMode = 2'(VEC_MODE[i]);
      tick(2);
      sigIn = (VEC_MODE[i] == 1 || VEC_MODE[i] == 3);
      tick(2);
      prevSecond = secondVal;
      measure(VEC_MODE[i], VEC_A[i], VEC_B[i], 1'b1, s1, s2);
      check("R3 done set", captureDone, 1);
      check("R3 firstVal stamp", firstVal, s1);
      check("R3 secondVal held", secondVal, prevSecond);
      doRead();
      check("R4 secondVal stamp", secondVal, s2);
      check("R4 done cleared", captureDone, 0);
      check("R5 width for mode", int'(CNT_W'(secondVal - firstVal)), VEC_A[i]);
    end

    // R6: period mode, closing edge does not open the next measurement
    measMode = 2'b10; tick(2); sigIn = 1'b0; tick(2);
    measure(2, 4, 2, 1'b0, s1, s2);
    doRead();
    drv(1'b0, x); tick(1); drv(1'b1, s3); tick(2);
    check("R6 one more rise does not complete", captureDone, 0);
    drv(1'b0, x); tick(1); drv(1'b1, s4);
    check("R6 next pair completes", captureDone, 1);
    check("R6 next pair first stamp", firstVal, s3);
    doRead();
    check("R6 next pair second stamp", secondVal, s4);

    // R7: third edge before the read
    measMode = 2'b00; tick(2); sigIn = 1'b0; tick(2);
    measure(0, 3, 0, 1'b0, s1, s2);
    tick(1);
    drv(1'b1, s3);
    tick(1);
    check("R7 firstVal kept after third edge", firstVal, s1);
    doRead();
    check("R7 secondVal is earlier pair", secondVal, s2);
    check("R7 width of earlier pair", int'(CNT_W'(secondVal - firstVal)), 3);
    tick(2);
    drv(1'b0, s4);
    check("R7 buffered third edge starts next", firstVal, s3);
    doRead();
    check("R7 closing stamp", secondVal, s4);

    // R8: fourth edge before the read
    tick(2);
    measure(0, 2, 0, 1'b0, s1, s2);
    tick(1);
    measure(0, 5, 0, 1'b0, s3, s4);
    tick(1);
    check("R8 firstVal overwritten", firstVal, s3);
    check("R8 done set", captureDone, 1);
    doRead();
    check("R8 secondVal newer", secondVal, s4);
    check("R8 width newer", int'(CNT_W'(secondVal - firstVal)), 5);

    // R9: read in the same clock as a completing edge
    tick(2);
    measure(0, 2, 0, 1'b0, s1, s2);
    tick(1);
    drv(1'b1, s3);
    tick(2);
    sigIn = 1'b0; readFirst = 1'b1; s4 = cyc & 16'hFFFF;
    @(negedge clk);
    readFirst = 1'b0;
    check("R9 firstVal new", firstVal, s3);
    check("R9 secondVal pre-edge buffer", secondVal, s2);
    check("R9 done stays set", captureDone, 1);
    doRead();
    check("R9 later read gives new second", secondVal, s4);
    check("R9 done cleared", captureDone, 0);

    // R10: mode change abandons a half measurement
    tick(2);
    drv(1'b1, x);
    tick(1);
    measMode = 2'b10;
    tick(2);
    drv(1'b0, x); tick(1); drv(1'b1, s1); tick(1);
    check("R10 no completion after mode change", captureDone, 0);
    drv(1'b0, x); tick(1); drv(1'b1, s2);
    check("R10 fresh pair completes", captureDone, 1);
    check("R10 fresh first stamp", firstVal, s1);
    doRead();
    check("R10 fresh second stamp", secondVal, s2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

endmodule